// File: doc/BRIEF.md
# Critical-Range Routing Interface for a Bus Master

This block sits on the master side of an on-chip packet network, between a bus master and the packet fabric. Each outgoing request is checked against a programmable critical address window. A request whose address falls inside the window is marked with a one-bit critical flag in its header. The block picks the destination node by looking up the addressed target in a small route table. That table has one extra entry, which holds the node of a reliable backup memory.

The block remembers, for each transaction tag, which node the request went to. When a response comes back, its source node is compared with that recorded node. A difference means the response came from somewhere other than the intended memory, which is an indirect sign of a fault in the main memory. Every difference raises a one-cycle event.

Under the permanent-fault policy, a difference on a critical read or instruction fetch switches the block into backup mode. In backup mode, later critical reads and fetches are sent straight to the backup node. Critical writes keep their normal route. Backup mode is sticky until reset or until a configuration write clears it. Under the transient policy, a difference only raises the event.

Top module: `crit_route_ni`

## Requirements
- R1: After a synchronous active-low reset, `hdr_valid`, `mis_evt` and `backup_mode` are 0. The reset state is:
  - critical window: `CRIT_LO_RST` to `CRIT_HI_RST`;
  - route entry t: node t;
  - backup entry: node `N_TGT`;
  - every tag record: node 0, not a critical read.
- R2: A request accepted at a clock edge appears on the `hdr_*` outputs after that same edge, for exactly one cycle. `hdr_crit` is 1 exactly when `cfg_lo <= req_addr <= cfg_hi` (both bounds inclusive).
- R3: The target index is the top `$clog2(N_TGT)` bits of the address. `hdr_route` is the route entry of that target, with one exception: a critical read or fetch issued while `backup_mode` is 1.
- R4: A configuration write (`cfg_we`=1) takes effect from the next request onward. Register selects:
  - 0: window low bound;
  - 1: window high bound;
  - 2: clear backup mode when `cfg_wdata[0]`=1;
  - 3: backup entry (`cfg_wdata[NODE_W-1:0]`);
  - 4+t: route entry t.
- R5: For each request, the chosen node is recorded under its tag. A response with `rsp_src` different from the node recorded for `rsp_tag` makes `mis_evt` 1 for the single cycle after the response edge.
- R6: With `perm_mode`=1, a mismatching response to a critical read or fetch sets `backup_mode` after that edge. From then on, critical reads and fetches are routed to the backup entry. A later response from that node is not a mismatch.
- R7: In backup mode, critical writes still take their route-table entry.
- R8: With `perm_mode`=0, a mismatch raises `mis_evt` but leaves `backup_mode` unchanged.
- R9: A mismatch on a response to a non-critical request, or to a write, raises `mis_evt` but never sets `backup_mode`.
- R10: `backup_mode` holds until reset or a clear write. When a switching mismatch and a clear arrive on the same edge, the mismatch wins.
- R11: Request kind is 0 read, 1 write, 2 instruction fetch, 3 treated as read. A fetch is flagged and routed exactly like a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| perm_mode | input | 1 | 1 = permanent policy, 0 = transient policy |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request address |
| req_kind | input | 2 | Request kind (read, write, fetch) |
| req_tag | input | TAG_W | Transaction tag |
| hdr_valid | output | 1 | Header present |
| hdr_addr | output | AW | Header address |
| hdr_kind | output | 2 | Header request kind |
| hdr_tag | output | TAG_W | Header tag |
| hdr_crit | output | 1 | Critical flag bit |
| hdr_route | output | NODE_W | Destination node |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_src | input | NODE_W | Source node of the response |
| mis_evt | output | 1 | One-cycle source-mismatch event |
| backup_mode | output | 1 | Critical reads redirected to backup |

## Verification
The bench uses the default parameters:
- AW=16 and N_TGT=4, so the target index is address bits 15:14;
- NODE_W=4 and TAG_W=2, so four transactions can be outstanding.

The bench moves the critical window to 0x4100..0x41FF and gives target 1 and the backup entry their own nodes. This lets a single target carry both critical and non-critical traffic. Requests at both window bounds, and one address on each side of them, are in reach.

With four tags, a tag can be reused while its response is still pending. This puts the following in reach:
- mismatches under both policies;
- mismatches on writes and on non-critical reads;
- routing after the switch;
- a clear that lands on the same edge as a switching mismatch.

// File: rtl/crni_pkg.sv
// Package: shared encodings for the critical-range routing interface.
// Assumes request kinds and configuration selects are fixed by the requirements.
package crni_pkg;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_FETCH = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    localparam int SEL_LO    = 0;
    localparam int SEL_HI    = 1;
    localparam int SEL_CLR   = 2;
    localparam int SEL_BK    = 3;
    localparam int SEL_ROUTE = 4;

    // Any kind other than a write is a read-like access (fetch included).
    function automatic logic is_read_like(input logic [1:0] k);
        return k != K_WRITE;
    endfunction

endpackage

// File: rtl/crni_range_cmp.sv
// Module: holds the programmable critical window and compares an address with it.
// Assumes both bounds are inclusive; the window is empty when lo > hi.
module crni_range_cmp #(
    parameter int AW = 16,
    parameter int CFG_AW = 3,
    parameter logic [AW-1:0] LO_RST = '0,
    parameter logic [AW-1:0] HI_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [AW-1:0]     addr,
    output logic              in_range
);
    import crni_pkg::*;

    logic [AW-1:0] lo_q, hi_q;
    logic          wr_lo, wr_hi;

    assign wr_lo = cfg_we && (cfg_addr == CFG_AW'(SEL_LO));
    assign wr_hi = cfg_we && (cfg_addr == CFG_AW'(SEL_HI));

    // Load the window bounds from configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
        end else begin
            if (wr_lo) lo_q <= cfg_wdata;
            if (wr_hi) hi_q <= cfg_wdata;
        end
    end

    // Inclusive window test.
    always_comb begin
        in_range = (addr >= lo_q) && (addr <= hi_q);
    end

endmodule

// File: rtl/crni_route_lut.sv
// Module: source-routing table with one node entry per target plus a backup entry.
// Assumes the target index is the top bits of the address, decoded by the caller.
module crni_route_lut #(
    parameter int AW = 16,
    parameter int N_TGT = 4,
    parameter int NODE_W = 4,
    parameter int CFG_AW = 3,
    localparam int TB = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [TB-1:0]     tgt,
    input  logic              use_backup,
    output logic [NODE_W-1:0] node
);
    import crni_pkg::*;

    logic [NODE_W-1:0] entry_q [N_TGT];
    logic [NODE_W-1:0] bk_q;

    // One register per target entry, each with its own select decode.
    for (genvar t = 0; t < N_TGT; t++) begin : g_entry
        logic sel;
        assign sel = cfg_we && (cfg_addr == CFG_AW'(SEL_ROUTE + t));

        // Load route entry t.
        always_ff @(posedge clk) begin
            if (!rst_n)   entry_q[t] <= NODE_W'(t);
            else if (sel) entry_q[t] <= cfg_wdata[NODE_W-1:0];
        end
    end

    // Load the backup entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bk_q <= NODE_W'(N_TGT);
        else if (cfg_we && (cfg_addr == CFG_AW'(SEL_BK)))
            bk_q <= cfg_wdata[NODE_W-1:0];
    end

    // Select the backup entry or the target entry.
    always_comb begin
        node = use_backup ? bk_q : entry_q[tgt];
    end

endmodule

// File: rtl/crni_rsp_monitor.sv
// Module: records the node each tag was sent to and compares response sources.
// Raises a one-cycle event on a mismatch and owns the sticky backup-mode state.
// Assumes a tag is not reused until its response has returned.
module crni_rsp_monitor #(
    parameter int TAG_W = 2,
    parameter int NODE_W = 4,
    localparam int DEPTH = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [NODE_W-1:0] wr_node,
    input  logic              wr_crit_rd,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [NODE_W-1:0] rsp_src,
    input  logic              perm_mode,
    input  logic              clr,
    output logic              mis_evt,
    output logic              backup_mode
);
    logic [NODE_W-1:0] exp_node_q [DEPTH];
    logic              crit_rd_q  [DEPTH];
    logic              mis;
    logic              do_switch;

    // Record the node and kind of each issued request under its tag.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                exp_node_q[i] <= '0;
                crit_rd_q[i]  <= 1'b0;
            end else if (wr_en && (wr_tag == TAG_W'(i))) begin
                exp_node_q[i] <= wr_node;
                crit_rd_q[i]  <= wr_crit_rd;
            end
        end
    end

    // Compare the response source with the recorded node.
    always_comb begin
        mis       = rsp_valid && (rsp_src != exp_node_q[rsp_tag]);
        do_switch = mis && crit_rd_q[rsp_tag] && perm_mode;
    end

    // Event pulse and sticky switch state; a switching mismatch beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_evt     <= 1'b0;
            backup_mode <= 1'b0;
        end else begin
            mis_evt <= mis;
            if (do_switch) backup_mode <= 1'b1;
            else if (clr)  backup_mode <= 1'b0;
        end
    end

    // R10: backup mode is held unless a clear is requested.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && !clr) |=> backup_mode);

    // R8: the transient policy never enters backup mode.
    a_r8_transient_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (!perm_mode && !backup_mode) |=> !backup_mode);

    // R5: an event always follows a response.
    a_r5_evt_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        mis_evt |-> $past(rsp_valid));

    // R6: entering backup mode needs a response under the permanent policy.
    a_r6_switch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backup_mode) |-> ($past(perm_mode) && $past(rsp_valid) && mis_evt));

endmodule

// File: rtl/crit_route_ni.sv
// Module: top of the critical-range routing interface.
// Flags critical requests, picks their route, and registers the header for one cycle.
// Assumes no back-pressure from the fabric: a request is accepted every valid cycle.
module crit_route_ni #(
    parameter int AW = 16,
    parameter int N_TGT = 4,
    parameter int NODE_W = 4,
    parameter int TAG_W = 2,
    parameter logic [AW-1:0] CRIT_LO_RST = 16'h1000,
    parameter logic [AW-1:0] CRIT_HI_RST = 16'h1FFF,
    localparam int CFG_AW = $clog2(N_TGT + 4),
    localparam int TB = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              perm_mode,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_kind,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              hdr_valid,
    output logic [AW-1:0]     hdr_addr,
    output logic [1:0]        hdr_kind,
    output logic [TAG_W-1:0]  hdr_tag,
    output logic              hdr_crit,
    output logic [NODE_W-1:0] hdr_route,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [NODE_W-1:0] rsp_src,
    output logic              mis_evt,
    output logic              backup_mode
);
    import crni_pkg::*;

    logic              in_range;
    logic              crit_rd;
    logic              use_backup;
    logic [NODE_W-1:0] node;
    logic [TB-1:0]     tgt;
    logic              clr;

    assign tgt = (N_TGT > 1) ? TB'(req_addr >> (AW - TB)) : '0;
    assign clr = cfg_we && (cfg_addr == CFG_AW'(SEL_CLR)) && cfg_wdata[0];

    crni_range_cmp #(
        .AW(AW), .CFG_AW(CFG_AW), .LO_RST(CRIT_LO_RST), .HI_RST(CRIT_HI_RST)
    ) u_range (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .addr(req_addr), .in_range(in_range)
    );

    // A critical read-like request goes to the backup while in backup mode.
    always_comb begin
        crit_rd    = in_range && is_read_like(req_kind);
        use_backup = crit_rd && backup_mode;
    end

    crni_route_lut #(
        .AW(AW), .N_TGT(N_TGT), .NODE_W(NODE_W), .CFG_AW(CFG_AW)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tgt(tgt), .use_backup(use_backup), .node(node)
    );

    crni_rsp_monitor #(
        .TAG_W(TAG_W), .NODE_W(NODE_W)
    ) u_mon (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid), .wr_tag(req_tag), .wr_node(node), .wr_crit_rd(crit_rd),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_src(rsp_src),
        .perm_mode(perm_mode), .clr(clr),
        .mis_evt(mis_evt), .backup_mode(backup_mode)
    );

    // Register the outgoing header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_valid <= 1'b0;
            hdr_addr  <= '0;
            hdr_kind  <= '0;
            hdr_tag   <= '0;
            hdr_crit  <= 1'b0;
            hdr_route <= '0;
        end else begin
            hdr_valid <= req_valid;
            if (req_valid) begin
                hdr_addr  <= req_addr;
                hdr_kind  <= req_kind;
                hdr_tag   <= req_tag;
                hdr_crit  <= in_range;
                hdr_route <= node;
            end
        end
    end

    // R2: a header is only ever produced from a request one edge earlier.
    a_r2_hdr_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(req_valid));

    // R2: the header carries the address that was presented.
    a_r2_hdr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_addr == $past(req_addr)));

    // R7: with the window unchanged, a critical write is routed like a non-critical access.
    a_r7_write_stable_route: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_kind == K_WRITE) |-> $past(!use_backup));

endmodule

// File: tb/sim_crit_route_ni.sv
module sim_crit_route_ni;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        perm_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_tag = '0;
    logic        hdr_valid;
    logic [15:0] hdr_addr;
    logic [1:0]  hdr_kind;
    logic [1:0]  hdr_tag;
    logic        hdr_crit;
    logic [3:0]  hdr_route;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_tag = '0;
    logic [3:0]  rsp_src = '0;
    logic        mis_evt;
    logic        backup_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit seen_edge = 0;
    bit finished = 0;

    crit_route_ni u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .perm_mode(perm_mode), .req_valid(req_valid),
        .req_addr(req_addr), .req_kind(req_kind), .req_tag(req_tag),
        .hdr_valid(hdr_valid), .hdr_addr(hdr_addr), .hdr_kind(hdr_kind),
        .hdr_tag(hdr_tag), .hdr_crit(hdr_crit), .hdr_route(hdr_route),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_src(rsp_src),
        .mis_evt(mis_evt), .backup_mode(backup_mode)
    );

    always #5 clk = ~clk;

    // Reference model state.
    logic [15:0] m_lo, m_hi;
    logic [3:0]  m_rt [4];
    logic [3:0]  m_bk;
    logic        m_bm;
    logic [3:0]  m_tn [4];
    logic        m_tc [4];
    logic        e_hv, e_crit, e_evt, e_bm;
    logic [15:0] e_addr;
    logic [1:0]  e_kind, e_tag;
    logic [3:0]  e_route;
    string       e_rtag;

    always @(posedge clk) begin
        seen_edge <= 1;
        if (!rst_n) begin
            m_lo = 16'h1000;
            m_hi = 16'h1FFF;
            for (int i = 0; i < 4; i++) begin
                m_rt[i] = 4'(i);
                m_tn[i] = 0;
                m_tc[i] = 0;
            end
            m_bk = 4'd4;
            m_bm = 0;
            e_hv = 0;
            e_evt = 0;
            e_bm = 0;
            e_rtag = "R1";
        end else begin
            bit crit, rd, mis, nbm;
            logic [3:0] rt;
            crit = (req_addr >= m_lo) && (req_addr <= m_hi);
            rd = (req_kind != 2'd1);
            rt = (crit && rd && m_bm) ? m_bk : m_rt[req_addr[15:14]];
            e_rtag = (crit && rd && m_bm) ? "R6/R11" : (crit && !rd) ? "R7/R3" : "R3";
            e_hv = req_valid;
            if (req_valid) begin
                e_addr = req_addr;
                e_kind = req_kind;
                e_tag = req_tag;
                e_crit = crit;
                e_route = rt;
            end
            mis = rsp_valid && (rsp_src != m_tn[rsp_tag]);
            e_evt = mis;
            nbm = m_bm;
            if (mis && m_tc[rsp_tag] && perm_mode)
                nbm = 1;
            else if (cfg_we && cfg_addr == 3'd2 && cfg_wdata[0])
                nbm = 0;
            m_bm = nbm;
            e_bm = nbm;
            if (req_valid) begin
                m_tn[req_tag] = rt;
                m_tc[req_tag] = crit && rd;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_lo = cfg_wdata;
                    3'd1: m_hi = cfg_wdata;
                    3'd3: m_bk = cfg_wdata[3:0];
                    3'd4, 3'd5, 3'd6, 3'd7: m_rt[cfg_addr - 3'd4] = cfg_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
        end
    endtask

    // Per-clock comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (seen_edge && !finished) begin
            check("R1/R2 hdr_valid", 32'(hdr_valid), 32'(e_hv));
            check("R5 mis_evt", 32'(mis_evt), 32'(e_evt));
            check("R6/R8/R9/R10 backup_mode", 32'(backup_mode), 32'(e_bm));
            if (e_hv) begin
                check("R2 hdr_crit", 32'(hdr_crit), 32'(e_crit));
                check({e_rtag, " hdr_route"}, 32'(hdr_route), 32'(e_route));
                check("R2 hdr_addr", 32'(hdr_addr), 32'(e_addr));
                check("R11 hdr_kind", 32'(hdr_kind), 32'(e_kind));
                check("R2 hdr_tag", 32'(hdr_tag), 32'(e_tag));
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
        rsp_valid = 0;
        cfg_we = 0;
    endtask

    task automatic req(input logic [15:0] a, input logic [1:0] k, input logic [1:0] t);
        idle();
        req_valid = 1;
        req_addr = a;
        req_kind = k;
        req_tag = t;
    endtask

    task automatic rsp(input logic [1:0] t, input logic [3:0] s);
        idle();
        rsp_valid = 1;
        rsp_tag = t;
        rsp_src = s;
    endtask

    task automatic cfg(input logic [2:0] a, input logic [15:0] d);
        idle();
        cfg_we = 1;
        cfg_addr = a;
        cfg_wdata = d;
    endtask

    task automatic finish_run();
        idle();
        idle();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            failures++;
            finished = 1;
            $display("FAIL watchdog actual=%0d expected<5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, including default window and routes.
        rst_n = 0;
        idle();
        idle();
        rst_n = 1;
        req(16'h1000, 2'd0, 2'd0);  // default window lower bound, target 0 -> node 0
        req(16'hC000, 2'd0, 2'd1);  // target 3 -> node 3
        idle();
        // R4: program window, route entry 1 and the backup entry.
        cfg(3'd0, 16'h4100);
        cfg(3'd1, 16'h41FF);
        cfg(3'd5, 16'h0009);
        cfg(3'd3, 16'h000C);
        // R2/R3: bounds and neighbours of the window.
        req(16'h0010, 2'd0, 2'd0);
        req(16'h4100, 2'd0, 2'd1);
        req(16'h41FF, 2'd1, 2'd2);
        req(16'h4200, 2'd0, 2'd3);
        req(16'h40FF, 2'd2, 2'd3);
        req(16'h1000, 2'd0, 2'd3);  // old window no longer critical
        // R5: matching response, no event.
        rsp(2'd1, 4'd9);
        idle();
        // R8: transient policy, mismatch gives event only.
        perm_mode = 0;
        rsp(2'd1, 4'd12);
        idle();
        perm_mode = 1;
        // R9: mismatch on non-critical read and on critical write.
        req(16'h4000, 2'd0, 2'd0);
        rsp(2'd0, 4'd5);
        rsp(2'd2, 4'd12);
        idle();
        // R6/R11: critical fetch mismatch switches.
        req(16'h4150, 2'd2, 2'd3);
        rsp(2'd3, 4'd12);
        idle();
        // R6/R7/R11: routing in backup mode.
        req(16'h4120, 2'd0, 2'd0);
        req(16'h4121, 2'd1, 2'd1);
        req(16'h4122, 2'd2, 2'd2);
        req(16'h4300, 2'd0, 2'd3);
        rsp(2'd0, 4'd12);  // from backup: matches, no event
        rsp(2'd1, 4'd9);
        idle();
        // R10: sticky, then a clear write.
        idle();
        cfg(3'd2, 16'h0000);  // bit0=0: no clear
        cfg(3'd2, 16'h0001);
        idle();
        req(16'h4130, 2'd0, 2'd0);  // back on the main route
        // R10: clear and switching mismatch on the same edge; set wins.
        idle();
        rsp(2'd0, 4'd12);
        cfg_we = 1;
        cfg_addr = 3'd2;
        cfg_wdata = 16'h0001;
        idle();
        idle();
        cfg(3'd2, 16'h0001);
        idle();
        // R1: reset in the middle of backup mode.
        req(16'h4140, 2'd0, 2'd1);
        rsp(2'd1, 4'd3);
        idle();
        rst_n = 0;
        idle();
        rst_n = 1;
        req(16'h4140, 2'd0, 2'd1);
        finish_run();
    end
endmodule